// File: doc/BRIEF.md
# Memory-Mapped Serial NOR Flash Read Controller

This block sits between a simple request/acknowledge bus slave port and a serial NOR flash device. A bus read in the flash window becomes one complete flash read transaction. Chip select is pulled low and the read opcode goes out on a single line. The 24-bit address follows, then a configurable number of idle dummy clocks. Four data bytes are then shifted in, and the word is returned with the lowest-addressed byte in the least significant position. The bus is acknowledged only once the last data bit has been captured.

A small register window configures the read opcode, the dummy clock count, the lane width (one, two or four data lines) and an even serial clock divisor. The same window offers a manual path: software holds chip select through a control bit and moves single bytes through a data register, which lets it issue any flash command. The serial interface runs in clock mode 0. A build parameter chooses whether the reset configuration targets single-line reads or four-line reads. The default divisor of four keeps the serial clock at a quarter of the system clock, because half-rate sampling would need extra input delay.

Top module: `spi_flash_ctrl`

## Requirements
- R1: A bus read with reg_sel_i=0 drives cs_no low, then sends the opcode as 8 clocks on dq_o[0], MSB first. The 24-bit addr_i follows MSB first, then the dummy clocks, then 32 data bits. rdata_o[7:0] holds the byte at addr_i and rdata_o[31:24] the byte at addr_i+3; addresses wrap at 24 bits. A bus write with reg_sel_i=0 is acknowledged and causes no serial clock.
- R2: Config bits [13:12] select the lanes: 0 gives one lane (output dq_o[0], input dq_i[1]), 1 gives dq[1:0], and 2 or 3 gives dq[3:0]. Address, data and manual bytes use the selected lanes, with the higher-numbered line carrying the earlier bit. The opcode always uses one lane.
- R3: Config register (reg_sel_i=1, addr_i[3:2]=0) bits [7:0] set the read opcode and bits [11:8] the dummy clock count; a count of 0 omits the dummy phase.
- R4: Config bits [23:16] hold the divisor D. The serial clock stays high for max(1, D>>1) system cycles per pulse, and the field reads back as the even divisor in use (odd values round down, 0 and 1 read as 2).
- R5: After reset the config register reads 0x00040003 when QUAD_DEFAULT=0, and 0x000426EB when QUAD_DEFAULT=1.
- R6: sck_o is low while no transfer runs, dq_o changes only while sck_o is low, and dq_i is sampled on the rising edge of sck_o.
- R7: cs_no is low at every rising serial clock of a read transaction and is high in the cycle of its acknowledge, unless manual chip select is held.
- R8: ack_o is a one-cycle pulse. For a flash read it comes after the last data rising edge, with exactly 8 + 24/L + dummy + 32/L rising edges in the transaction.
- R9: Control register (addr_i[3:2]=1) bit 0 holds cs_no low while set and releases it when cleared.
- R10: A write to the data register (addr_i[3:2]=2) shifts out wdata_i[7:0] MSB first in 8/L clocks and stores the received bits. A read of that register returns the stored byte and causes no serial clock.
- R11: dq_oe_o is 4'b0001 during the opcode and equals the lane mask during address bits. It is zero during dummy and data clocks. During a manual byte it is the lane mask, or zero when control bit 1 is set and more than one lane is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request, held until ack_o |
| we_i | input | 1 | Bus write when high |
| reg_sel_i | input | 1 | 1 selects the register window, 0 the flash window |
| addr_i | input | 24 | Flash byte address, or register index in bits [3:2] |
| wdata_i | input | 32 | Bus write data |
| rdata_o | output | 32 | Bus read data, valid with ack_o |
| ack_o | output | 1 | One-cycle access completion |
| sck_o | output | 1 | Serial clock |
| cs_no | output | 1 | Flash chip select, active low |
| dq_i | input | 4 | Serial data lines in |
| dq_o | output | 4 | Serial data lines out |
| dq_oe_o | output | 4 | Per-line output enable |

## Verification
The assertions assume that a bus master keeps req_i high and its other bus inputs stable until ack_o, then drops req_i. They also assume that the configuration is never rewritten while a serial transfer runs, so the divisor and lane width stay fixed across one transaction. The stimulus issues one access at a time through a single task that raises req_i and releases it in the cycle it sees ack_o. It changes the configuration only between accesses, and it clears manual chip select before any flash read, so no read overlaps a held manual select.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int ADDR_BITS = 24;
  localparam int WORD_BITS = 32;
  localparam int HALF_W    = 7;
  localparam int CNT_W     = 6;

  typedef enum logic [1:0] {LN_1 = 2'd0, LN_2 = 2'd1, LN_4 = 2'd2} lane_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_ADDR, S_DUMMY, S_DATA, S_MAN, S_DONE
  } state_e;

  typedef struct packed {
    logic [7:0]        cmd;
    logic [3:0]        dummy;
    lane_e             lanes;
    logic [HALF_W-1:0] half;
  } cfg_t;

  function automatic logic [3:0] lane_mask(lane_e l);
    case (l)
      LN_1:    return 4'b0001;
      LN_2:    return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [1:0] lane_shift(lane_e l);
    case (l)
      LN_1:    return 2'd0;
      LN_2:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/sfc_regs.sv
module sfc_regs
  import sfc_pkg::*;
#(
  parameter bit QUAD_DEFAULT = 1'b0,
  parameter int DIV_DEFAULT  = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [1:0]  sel_i,
  input  logic [31:0] wdata_i,
  input  logic        rx_we_i,
  input  logic [7:0]  rx_byte_i,
  output cfg_t        cfg_o,
  output logic        man_cs_o,
  output logic        man_rx_dir_o,
  output logic [31:0] rdata_o
);
  localparam logic [7:0]        CMD_RST   = QUAD_DEFAULT ? 8'hEB : 8'h03;
  localparam logic [3:0]        DUMMY_RST = QUAD_DEFAULT ? 4'd6 : 4'd0;
  localparam logic [1:0]        LANE_RST  = QUAD_DEFAULT ? 2'd2 : 2'd0;
  localparam int                HALF_INT  = (DIV_DEFAULT < 2) ? 1 : DIV_DEFAULT / 2;
  localparam logic [HALF_W-1:0] HALF_RST  = HALF_W'(HALF_INT);

  logic [7:0]        cmd_q;
  logic [3:0]        dummy_q;
  logic [1:0]        lane_raw_q;
  logic [HALF_W-1:0] half_q;
  logic              cs_q, dir_q;
  logic [7:0]        rx_q;
  logic [HALF_W-1:0] half_wr;
  logic              unused_wbits;

  assign half_wr      = (wdata_i[23:17] == '0) ? HALF_W'(1) : wdata_i[23:17];
  assign unused_wbits = ^{wdata_i[31:24], wdata_i[16], wdata_i[15:14]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q      <= CMD_RST;
      dummy_q    <= DUMMY_RST;
      lane_raw_q <= LANE_RST;
      half_q     <= HALF_RST;
      cs_q       <= 1'b0;
      dir_q      <= 1'b0;
      rx_q       <= '0;
    end else begin
      if (wr_i && sel_i == 2'd0) begin
        cmd_q      <= wdata_i[7:0];
        dummy_q    <= wdata_i[11:8];
        lane_raw_q <= wdata_i[13:12];
        half_q     <= half_wr;
      end
      if (wr_i && sel_i == 2'd1) begin
        cs_q  <= wdata_i[0];
        dir_q <= wdata_i[1];
      end
      if (rx_we_i) rx_q <= rx_byte_i;
    end
  end

  always_comb begin
    cfg_o.cmd   = cmd_q;
    cfg_o.dummy = dummy_q;
    cfg_o.half  = half_q;
    case (lane_raw_q)
      2'd0:    cfg_o.lanes = LN_1;
      2'd1:    cfg_o.lanes = LN_2;
      default: cfg_o.lanes = LN_4;
    endcase
  end

  always_comb begin
    case (sel_i)
      2'd0:    rdata_o = {8'h00, half_q, 1'b0, 2'b00, lane_raw_q, dummy_q, cmd_q};
      2'd1:    rdata_o = {30'b0, dir_q, cs_q};
      2'd2:    rdata_o = {24'b0, rx_q};
      default: rdata_o = '0;
    endcase
  end

  assign man_cs_o     = cs_q;
  assign man_rx_dir_o = dir_q;

  p_half_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_q != '0);
endmodule

// File: rtl/sfc_shift_eng.sv
module sfc_shift_eng
  import sfc_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [CNT_W-1:0]     nclk_i,
  input  lane_e                lanes_i,
  input  logic [3:0]           oe_i,
  input  logic [WORD_BITS-1:0] tx_i,
  input  logic [HALF_W-1:0]    half_i,
  input  logic [3:0]           dq_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 sck_o,
  output logic [3:0]           dq_o,
  output logic [3:0]           dq_oe_o,
  output logic [WORD_BITS-1:0] rx_o
);
  logic                 busy_q, done_q, sck_q;
  logic [HALF_W-1:0]    cnt_q;
  logic [CNT_W-1:0]     left_q;
  logic [WORD_BITS-1:0] tx_q, rx_q, tx_next, rx_next;
  logic [3:0]           oe_q;
  lane_e                lanes_q;

  always_comb begin
    case (lanes_q)
      LN_1: begin
        rx_next = {rx_q[WORD_BITS-2:0], dq_i[1]};
        tx_next = {tx_q[WORD_BITS-2:0], 1'b0};
        dq_o    = {3'b000, tx_q[WORD_BITS-1]};
      end
      LN_2: begin
        rx_next = {rx_q[WORD_BITS-3:0], dq_i[1:0]};
        tx_next = {tx_q[WORD_BITS-3:0], 2'b00};
        dq_o    = {2'b00, tx_q[WORD_BITS-1 -: 2]};
      end
      default: begin
        rx_next = {rx_q[WORD_BITS-5:0], dq_i};
        tx_next = {tx_q[WORD_BITS-5:0], 4'b0000};
        dq_o    = tx_q[WORD_BITS-1 -: 4];
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      sck_q   <= 1'b0;
      cnt_q   <= '0;
      left_q  <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      oe_q    <= '0;
      lanes_q <= LN_1;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q  <= 1'b1;
        sck_q   <= 1'b0;
        cnt_q   <= half_i - HALF_W'(1);
        left_q  <= nclk_i;
        tx_q    <= tx_i;
        oe_q    <= oe_i;
        lanes_q <= lanes_i;
      end else if (busy_q) begin
        if (cnt_q != '0) begin
          cnt_q <= cnt_q - HALF_W'(1);
        end else begin
          cnt_q <= half_i - HALF_W'(1);
          if (!sck_q) begin
            sck_q <= 1'b1;
            rx_q  <= rx_next;
          end else begin
            sck_q  <= 1'b0;
            tx_q   <= tx_next;
            left_q <= left_q - CNT_W'(1);
            if (left_q == CNT_W'(1)) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end
          end
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign sck_o   = sck_q;
  assign dq_oe_o = busy_q ? oe_q : 4'b0000;
  assign rx_o    = rx_q;

  p_sck_idle_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sck_q);
  p_dq_hold_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_q && $past(sck_q)) |-> $stable(dq_o));
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/spi_flash_ctrl.sv
module spi_flash_ctrl
  import sfc_pkg::*;
#(
  parameter bit QUAD_DEFAULT = 1'b0,
  parameter int DIV_DEFAULT  = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic        reg_sel_i,
  input  logic [23:0] addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        ack_o,
  output logic        sck_o,
  output logic        cs_no,
  input  logic [3:0]  dq_i,
  output logic [3:0]  dq_o,
  output logic [3:0]  dq_oe_o
);
  state_e               state_q;
  logic                 go_q;
  logic [ADDR_BITS-1:0] addr_q;
  logic [7:0]           man_tx_q;
  logic [31:0]          rdata_q;

  cfg_t                 cfg;
  logic                 man_cs, man_rx_dir;
  logic [31:0]          reg_rdata;
  logic                 reg_wr, man_done;

  logic                 eng_busy, eng_done;
  logic [CNT_W-1:0]     ph_nclk;
  lane_e                ph_lanes;
  logic [3:0]           ph_oe;
  logic [WORD_BITS-1:0] ph_tx, eng_rx;
  logic [1:0]           lsh;

  assign lsh      = lane_shift(cfg.lanes);
  assign reg_wr   = (state_q == S_IDLE) && req_i && reg_sel_i && we_i && (addr_i[3:2] != 2'd2);
  assign man_done = (state_q == S_MAN) && eng_done;

  sfc_regs #(.QUAD_DEFAULT(QUAD_DEFAULT), .DIV_DEFAULT(DIV_DEFAULT)) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (reg_wr),
    .sel_i       (addr_i[3:2]),
    .wdata_i     (wdata_i),
    .rx_we_i     (man_done),
    .rx_byte_i   (eng_rx[7:0]),
    .cfg_o       (cfg),
    .man_cs_o    (man_cs),
    .man_rx_dir_o(man_rx_dir),
    .rdata_o     (reg_rdata)
  );

  // phase parameters for the engine, taken from the current state
  always_comb begin
    ph_nclk  = '0;
    ph_lanes = cfg.lanes;
    ph_oe    = 4'b0000;
    ph_tx    = '0;
    case (state_q)
      S_CMD: begin
        ph_nclk  = CNT_W'(8);
        ph_lanes = LN_1;
        ph_oe    = 4'b0001;
        ph_tx    = {cfg.cmd, 24'b0};
      end
      S_ADDR: begin
        ph_nclk = CNT_W'(ADDR_BITS) >> lsh;
        ph_oe   = lane_mask(cfg.lanes);
        ph_tx   = {addr_q, 8'b0};
      end
      S_DUMMY: ph_nclk = CNT_W'(cfg.dummy);
      S_DATA:  ph_nclk = CNT_W'(WORD_BITS) >> lsh;
      S_MAN: begin
        ph_nclk = CNT_W'(8) >> lsh;
        ph_oe   = (man_rx_dir && cfg.lanes != LN_1) ? 4'b0000 : lane_mask(cfg.lanes);
        ph_tx   = {man_tx_q, 24'b0};
      end
      default: ;
    endcase
  end

  sfc_shift_eng i_eng (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(go_q),
    .nclk_i (ph_nclk),
    .lanes_i(ph_lanes),
    .oe_i   (ph_oe),
    .tx_i   (ph_tx),
    .half_i (cfg.half),
    .dq_i   (dq_i),
    .busy_o (eng_busy),
    .done_o (eng_done),
    .sck_o  (sck_o),
    .dq_o   (dq_o),
    .dq_oe_o(dq_oe_o),
    .rx_o   (eng_rx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      go_q     <= 1'b0;
      addr_q   <= '0;
      man_tx_q <= '0;
      rdata_q  <= '0;
    end else begin
      go_q <= 1'b0;
      case (state_q)
        S_IDLE: if (req_i) begin
          if (reg_sel_i) begin
            if (we_i && addr_i[3:2] == 2'd2) begin
              man_tx_q <= wdata_i[7:0];
              state_q  <= S_MAN;
              go_q     <= 1'b1;
            end else begin
              if (!we_i) rdata_q <= reg_rdata;
              state_q <= S_DONE;
            end
          end else if (we_i) begin
            state_q <= S_DONE;
          end else begin
            addr_q  <= addr_i;
            state_q <= S_CMD;
            go_q    <= 1'b1;
          end
        end
        S_CMD: if (eng_done) begin
          state_q <= S_ADDR;
          go_q    <= 1'b1;
        end
        S_ADDR: if (eng_done) begin
          state_q <= (cfg.dummy != '0) ? S_DUMMY : S_DATA;
          go_q    <= 1'b1;
        end
        S_DUMMY: if (eng_done) begin
          state_q <= S_DATA;
          go_q    <= 1'b1;
        end
        S_DATA: if (eng_done) begin
          rdata_q <= {eng_rx[7:0], eng_rx[15:8], eng_rx[23:16], eng_rx[31:24]};
          state_q <= S_DONE;
        end
        S_MAN: if (eng_done) state_q <= S_DONE;
        S_DONE: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cs_no   = !(man_cs || state_q inside {S_CMD, S_ADDR, S_DUMMY, S_DATA});
  assign ack_o   = (state_q == S_DONE);
  assign rdata_o = rdata_q;

  p_cs_low_on_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && state_q != S_MAN) |-> !cs_no);
  p_ack_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  p_ack_after_shift_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (!eng_busy && !sck_o));
  p_oe_released_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q inside {S_DUMMY, S_DATA}) |-> (dq_oe_o == 4'b0000));
endmodule

// File: tb/test_spi_flash_ctrl.sv
module test_spi_flash_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, reg_sel = 1'b0;
  logic [23:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ack, sck, cs_n;
  logic [3:0]  dq_in = '0, dq_out, dq_oe;

  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  spi_flash_ctrl i_spi_flash_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .reg_sel_i(reg_sel),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .ack_o(ack),
    .sck_o(sck), .cs_no(cs_n), .dq_i(dq_in), .dq_o(dq_out), .dq_oe_o(dq_oe)
  );

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req_tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mem(input logic [23:0] a);
    logic [7:0] t;
    t = a[7:0] * 8'd7 + 8'd13;
    return t ^ a[15:8] ^ a[23:16];
  endfunction

  // reference flash model state
  int          lanes_n = 1, dummy_n = 0, half_n = 2;
  logic [23:0] cur_addr = '0;
  logic        man = 1'b0;
  logic [3:0]  man_oe = 4'b0001;
  logic [7:0]  resp = '0, man_cap = '0;
  int          mk = 0, rc = 0, tot_rise = 0, hi_len = 0;
  logic [7:0]  cmd_cap = '0;
  logic [23:0] addr_cap = '0;
  logic        prev_sck = 1'b0, prev_cs = 1'b1;
  logic [3:0]  prev_dq = '0;

  function automatic logic [3:0] mask_of(input int l);
    return (l == 1) ? 4'b0001 : (l == 2) ? 4'b0011 : 4'b1111;
  endfunction

  // bits of a byte at clock index m, placed on the input lanes
  function automatic logic [3:0] put_bits(input logic [7:0] b, input int m);
    logic [7:0] v;
    v = (b >> (8 - ((m * lanes_n) % 8) - lanes_n)) & 8'(mask_of(lanes_n));
    return (lanes_n == 1) ? {2'b00, v[0], 1'b0} : v[3:0];
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      int ac, pre, dc;
      ac  = 24 / lanes_n;
      dc  = 32 / lanes_n;
      pre = 8 + ac + dummy_n;
      if (prev_cs && !cs_n && !man) begin
        rc = 0; cmd_cap = '0; addr_cap = '0;
      end
      if (dq_out !== prev_dq) chk("R6 dq change while sck high", {31'b0, sck && prev_sck}, 0);
      if (prev_sck && !sck) begin
        chk("R4 sck high length", hi_len, half_n);
        hi_len = 0;
      end
      if (!prev_sck && sck) begin
        tot_rise++;
        chk("R7 cs low at rising edge", {31'b0, cs_n}, 0);
        if (man) begin
          man_cap = (man_cap << lanes_n) | 8'(dq_out & mask_of(lanes_n));
          chk("R11 manual oe", {28'b0, dq_oe}, {28'b0, man_oe});
          mk++;
          if (mk < 8 / lanes_n) dq_in = put_bits(resp, mk);
        end else begin
          if (rc < 8) begin
            cmd_cap = {cmd_cap[6:0], dq_out[0]};
            chk("R11 oe opcode", {28'b0, dq_oe}, 32'h1);
          end else if (rc < 8 + ac) begin
            addr_cap = (addr_cap << lanes_n) | 24'(dq_out & mask_of(lanes_n));
            chk("R11 oe address", {28'b0, dq_oe}, {28'b0, mask_of(lanes_n)});
          end else begin
            chk("R11 oe dummy/data", {28'b0, dq_oe}, 0);
          end
          rc++;
          if (rc >= pre && rc < pre + dc) begin
            int bp;
            bp = (rc - pre) * lanes_n;
            dq_in = put_bits(mem(cur_addr + 24'(bp / 8)), rc - pre);
          end
        end
      end
      if (sck) hi_len++;
      prev_sck = sck;
      prev_cs  = cs_n;
      prev_dq  = dq_out;
    end
  end

  int ack_rc = 0;
  logic ack_cs = 1'b0;

  task automatic bus(input logic sel, input logic w, input logic [23:0] a,
                     input logic [31:0] wd, output logic [31:0] rd);
    int n;
    @(negedge clk);
    reg_sel = sel; we = w; addr = a; wdata = wd; req = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!ack && n < 20000);
    if (!ack) chk("R8 ack timeout", 0, 1);
    rd = rdata; ack_rc = rc; ack_cs = cs_n;
    req = 1'b0;
    @(negedge clk);
    chk("R8 ack single cycle", {31'b0, ack}, 0);
  endtask

  task automatic cfg_wr(input logic [7:0] c, input int dum, input int lraw, input int div);
    logic [31:0] rd;
    bus(1'b1, 1'b1, 24'h0, {8'h00, 8'(div), 2'b00, 2'(lraw), 4'(dum), c}, rd);
    lanes_n = (lraw == 0) ? 1 : (lraw == 1) ? 2 : 4;
    dummy_n = dum;
    half_n  = (div < 2) ? 1 : div / 2;
  endtask

  task automatic flash_read(input logic [7:0] c, input logic [23:0] a);
    logic [31:0] rd, exp;
    cur_addr = a;
    bus(1'b0, 1'b0, a, 32'h0, rd);
    exp = {mem(a + 24'd3), mem(a + 24'd2), mem(a + 24'd1), mem(a)};
    chk("R1/R3 opcode", {24'b0, cmd_cap}, {24'b0, c});
    chk("R1/R2 address", {8'b0, addr_cap}, {8'b0, a});
    chk("R1/R2 read data", rd, exp);
    chk("R8/R3 rising edges at ack", ack_rc, 8 + 24 / lanes_n + dummy_n + 32 / lanes_n);
    chk("R7 cs high at ack", {31'b0, ack_cs}, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk("R8 watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int t0;
    repeat (3) @(negedge clk);
    chk("R7 reset cs_no", {31'b0, cs_n}, 1);
    chk("R6 reset sck", {31'b0, sck}, 0);
    chk("R11 reset oe", {28'b0, dq_oe}, 0);
    chk("R8 reset ack", {31'b0, ack}, 0);
    rst_n = 1'b1;

    bus(1'b1, 1'b0, 24'h0, 32'h0, rd);
    chk("R5 reset config", rd, 32'h0004_0003);

    flash_read(8'h03, 24'h012345);

    t0 = tot_rise;
    bus(1'b0, 1'b1, 24'h000400, 32'hDEAD_BEEF, rd);
    chk("R1 flash write no clocks", tot_rise, t0);

    cfg_wr(8'h3B, 8, 1, 6);
    flash_read(8'h3B, 24'hABCDE0);

    cfg_wr(8'hEB, 6, 2, 2);
    flash_read(8'hEB, 24'hFFFFFE);

    cfg_wr(8'h0B, 8, 0, 7);
    bus(1'b1, 1'b0, 24'h0, 32'h0, rd);
    chk("R4 odd divisor readback", rd, 32'h0006_080B);
    flash_read(8'h0B, 24'h000100);

    cfg_wr(8'h6B, 0, 3, 1);
    bus(1'b1, 1'b0, 24'h0, 32'h0, rd);
    chk("R4 divisor 1 readback", rd, 32'h0002_306B);
    flash_read(8'h6B, 24'h7FFFF0);

    // manual path, single lane
    cfg_wr(8'h03, 0, 0, 4);
    bus(1'b1, 1'b1, 24'h4, 32'h1, rd);
    repeat (3) @(negedge clk);
    chk("R9 manual cs held", {31'b0, cs_n}, 0);
    man = 1'b1; man_oe = 4'b0001; resp = 8'h3C; mk = 0; man_cap = '0;
    dq_in = put_bits(resp, 0);
    bus(1'b1, 1'b1, 24'h8, 32'h0000_00A5, rd);
    chk("R10 manual byte out", {24'b0, man_cap}, 32'hA5);
    chk("R10 manual clock count", mk, 8);
    t0 = tot_rise;
    bus(1'b1, 1'b0, 24'h8, 32'h0, rd);
    chk("R10 manual byte in", rd, 32'h3C);
    chk("R10 data read no clocks", tot_rise, t0);
    chk("R9 cs still held", {31'b0, cs_n}, 0);

    // manual path, four lanes receiving
    cfg_wr(8'h03, 0, 2, 4);
    bus(1'b1, 1'b1, 24'h4, 32'h3, rd);
    man_oe = 4'b0000; resp = 8'h96; mk = 0;
    dq_in = put_bits(resp, 0);
    bus(1'b1, 1'b1, 24'h8, 32'h0, rd);
    bus(1'b1, 1'b0, 24'h8, 32'h0, rd);
    chk("R10/R2 quad receive", rd, 32'h96);
    chk("R2 quad clock count", mk, 2);

    // four lanes sending
    bus(1'b1, 1'b1, 24'h4, 32'h1, rd);
    man_oe = 4'b1111; mk = 0; man_cap = '0;
    bus(1'b1, 1'b1, 24'h8, 32'h0000_00C3, rd);
    chk("R2/R10 quad send", {24'b0, man_cap}, 32'hC3);

    bus(1'b1, 1'b1, 24'h4, 32'h0, rd);
    repeat (2) @(negedge clk);
    chk("R9 manual cs released", {31'b0, cs_n}, 1);
    man = 1'b0;

    repeat (5) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule